// File: doc/BRIEF.md
# Per-Pin Input Glitch and Debounce Filter Bank

This block sits between the input synchronizers of a general-purpose I/O controller and the logic that samples pin levels. Each of its input lines can have filtering switched on or off on its own. A line with filtering on runs in one of two modes. In glitch mode, a new level is accepted only once it has been seen on two consecutive system-clock edges. In debounce mode, the line is checked on the strobes of a divided slow clock, which rejects pulses shorter than half the divided period.

All configuration arrives as per-pin bitmask writes that are active for one cycle. A 1 bit in a mask acts on that pin and a 0 bit leaves it alone. One divider value is shared by every line. The slow clock arrives as a one-cycle enable strobe in the system-clock domain. The divider counts these strobes and produces a sample strobe every DIV+1 slow ticks, which is half of a divided period of (DIV+1)*2 slow ticks.

Top module: `ifl_filter_bank`

## Requirements
- R1: After reset, filtering is off on every pin, every pin is in glitch mode and the divider value is 0, so each slow tick is a debounce strobe.
- R2: A 1 in `flt_on_i` turns filtering on for that pin and a 1 in `flt_off_i` turns it off, from the next clock edge. A 0 bit changes nothing. If a pin gets both in the same cycle, filtering ends up off.
- R3: A pin with filtering off drives `pin_o` from `pin_i` combinationally, with no clock edge in between.
- R4: In glitch mode, `pin_o` takes a new level on the second rising edge at which `pin_i` shows that level without a break. A level that is present at only one edge never reaches `pin_o`.
- R5: A 1 in `sel_glitch_i` puts that pin in glitch mode and a 1 in `sel_bounce_i` puts it in debounce mode. A 0 bit changes nothing. If a pin gets both in the same cycle, it ends up in glitch mode.
- R6: The debounce strobe occurs on every (DIV+1)-th slow tick, where DIV is the 14-bit value loaded through `div_we_i`/`div_i`.
- R7: In debounce mode, a new level reaches `pin_o` at the second debounce strobe that finds it unbroken since the level appeared. A pulse shorter than DIV+1 slow ticks never reaches the output, and `pin_o` changes only in cycles that follow a slow tick.
- R8: Each pin follows only its own enable and mode bits. Pins in different modes run side by side without affecting each other.
- R9: A divider write restarts the slow-tick count from zero, so the next strobe comes DIV+1 ticks after the write.
- R10: While a pin's filter is off, its filtered state tracks the input. Turning filtering on for a pin whose input is steady shows that level at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle strobe per slow-clock period |
| pin_i | input | NPINS | Synchronized raw pin levels |
| flt_on_i | input | NPINS | Write-1 mask that turns filtering on |
| flt_off_i | input | NPINS | Write-1 mask that turns filtering off |
| sel_glitch_i | input | NPINS | Write-1 mask that selects glitch mode |
| sel_bounce_i | input | NPINS | Write-1 mask that selects debounce mode |
| div_we_i | input | 1 | Load strobe for the divider value |
| div_i | input | DIV_W | Divider value DIV |
| pin_o | output | NPINS | Filtered pin levels |

## Verification
The hardest condition to reach is a debounce pulse that straddles exactly one strobe: it arms the filter but must not be accepted. Reaching it needs exact knowledge of the divider phase. The bench therefore drives slow ticks one at a time and reloads the divider before each debounce sequence, so that every strobe falls on a known tick. Pulses of two and three ticks are then placed before and across a strobe. The restart of the count by a reload is exposed the same way: a reload in the middle of a count moves acceptance two ticks later than a free-running count would.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  typedef enum logic {
    FM_GLITCH   = 1'b0,
    FM_DEBOUNCE = 1'b1
  } flt_mode_e;
endpackage

// File: rtl/ifl_cfg_regs.sv
module ifl_cfg_regs #(
  parameter int NPINS = 32,
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] flt_on_i,
  input  logic [NPINS-1:0] flt_off_i,
  input  logic [NPINS-1:0] sel_glitch_i,
  input  logic [NPINS-1:0] sel_bounce_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] bounce_o,
  output logic [DIV_W-1:0] div_o
);
  logic [NPINS-1:0] en_q, en_d;
  logic [NPINS-1:0] bnc_q, bnc_d;
  logic [DIV_W-1:0] div_q, div_d;

  // the off mask wins over the on mask; glitch selection wins over debounce
  always_comb begin
    en_d  = (en_q | flt_on_i) & ~flt_off_i;
    bnc_d = (bnc_q | sel_bounce_i) & ~sel_glitch_i;
    div_d = div_q;
    if (div_we_i) div_d = div_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      bnc_q <= '0;
      div_q <= '0;
    end else begin
      en_q  <= en_d;
      bnc_q <= bnc_d;
      div_q <= div_d;
    end
  end

  assign en_o     = en_q;
  assign bounce_o = bnc_q;
  assign div_o    = div_q;
endmodule

// File: rtl/ifl_tick_div.sv
module ifl_tick_div #(
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             stb_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q >= div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)        cnt_d = '0;
    else if (slow_tick_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // one strobe per DIV+1 slow ticks: half of the divided period
  assign stb_o = slow_tick_i & wrap & ~restart_i;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/ifl_pin_cell.sv
module ifl_pin_cell
  import ifl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  logic      en_i,
  input  flt_mode_e mode_i,
  input  logic      stb_i,
  output logic      pin_o
);
  logic cand_q, cand_d;
  logic arm_q, arm_d;
  logic out_q, out_d;
  logic steady;

  assign steady = (pin_i == cand_q);

  always_comb begin
    cand_d = pin_i;
    arm_d  = arm_q;
    out_d  = out_q;
    if (!en_i) begin
      out_d = pin_i;
      arm_d = 1'b0;
    end else if (mode_i == FM_GLITCH) begin
      arm_d = 1'b0;
      if (steady) out_d = pin_i;
    end else begin
      if (!steady) begin
        arm_d = 1'b0;
      end else if (stb_i) begin
        if (arm_q) out_d = pin_i;
        arm_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      arm_q  <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      cand_q <= cand_d;
      arm_q  <= arm_d;
      out_q  <= out_d;
    end
  end

  assign pin_o = en_i ? out_q : pin_i;
endmodule

// File: rtl/ifl_filter_bank.sv
module ifl_filter_bank
  import ifl_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick_i,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] flt_on_i,
  input  logic [NPINS-1:0] flt_off_i,
  input  logic [NPINS-1:0] sel_glitch_i,
  input  logic [NPINS-1:0] sel_bounce_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [NPINS-1:0] pin_o
);
  logic [NPINS-1:0] en_w;
  logic [NPINS-1:0] bnc_w;
  logic [DIV_W-1:0] div_w;
  logic [DIV_W-1:0] cnt_w;
  logic             stb_w;

  ifl_cfg_regs #(.NPINS(NPINS), .DIV_W(DIV_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .flt_on_i     (flt_on_i),
    .flt_off_i    (flt_off_i),
    .sel_glitch_i (sel_glitch_i),
    .sel_bounce_i (sel_bounce_i),
    .div_we_i     (div_we_i),
    .div_i        (div_i),
    .en_o         (en_w),
    .bounce_o     (bnc_w),
    .div_o        (div_w)
  );

  ifl_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_tick_i (slow_tick_i),
    .restart_i   (div_we_i),
    .div_i       (div_w),
    .stb_o       (stb_w),
    .cnt_o       (cnt_w)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    ifl_pin_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i[g]),
      .en_i   (en_w[g]),
      .mode_i (flt_mode_e'(bnc_w[g])),
      .stb_i  (stb_w),
      .pin_o  (pin_o[g])
    );
  end
endmodule

// File: rtl/ifl_filter_bank_chk.sv
module ifl_filter_bank_chk #(
  parameter int NPINS = 32,
  parameter int DIV_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slow_tick_i,
  input logic [NPINS-1:0] pin_i,
  input logic [NPINS-1:0] pin_o,
  input logic [NPINS-1:0] flt_on_i,
  input logic [NPINS-1:0] flt_off_i,
  input logic [NPINS-1:0] sel_glitch_i,
  input logic [NPINS-1:0] en_w,
  input logic [NPINS-1:0] bnc_w,
  input logic [DIV_W-1:0] div_w,
  input logic [DIV_W-1:0] cnt_w
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2: an off write leaves the pin passing its input on the next cycle
  a_r2_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && flt_off_i != '0) |=> (((pin_o ^ pin_i) & $past(flt_off_i)) == '0));

  // R2: an on write without an off write enables the pin
  a_r2_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && (flt_on_i & ~flt_off_i) != '0) |=> ((en_w & $past(flt_on_i & ~flt_off_i)) == $past(flt_on_i & ~flt_off_i)));

  // R5: glitch selection leaves the pin in glitch mode
  a_r5_glitch_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && sel_glitch_i != '0) |=> ((bnc_w & $past(sel_glitch_i)) == '0));

  // R4: a glitch-mode output never takes a level seen at only one edge
  a_r4_needs_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (((pin_o ^ $past(pin_o)) & en_w & $past(en_w) & ~$past(bnc_w)
                          & ($past(pin_i) ^ $past(pin_i, 2))) == '0));

  // R7: a debounce-mode output moves only after a slow tick
  a_r7_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && ((pin_o ^ $past(pin_o)) & en_w & $past(en_w) & $past(bnc_w)) != '0)
      |-> $past(slow_tick_i));

  // R9: the slow-tick count never runs past the divider value
  a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= div_w);
endmodule

bind ifl_filter_bank ifl_filter_bank_chk #(.NPINS(NPINS), .DIV_W(DIV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slow_tick_i  (slow_tick_i),
  .pin_i        (pin_i),
  .pin_o        (pin_o),
  .flt_on_i     (flt_on_i),
  .flt_off_i    (flt_off_i),
  .sel_glitch_i (sel_glitch_i),
  .en_w         (en_w),
  .bnc_w        (bnc_w),
  .div_w        (div_w),
  .cnt_w        (cnt_w)
);

// File: tb/tb_ifl_filter_bank.sv
module tb_ifl_filter_bank;
  localparam int CLK_P = 10;
  localparam int NP    = 32;
  localparam int DW    = 14;
  localparam int WD_CYC = 5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_tick_i = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] flt_on_i = '0;
  logic [NP-1:0] flt_off_i = '0;
  logic [NP-1:0] sel_glitch_i = '0;
  logic [NP-1:0] sel_bounce_i = '0;
  logic          div_we_i = 1'b0;
  logic [DW-1:0] div_i = '0;
  logic [NP-1:0] pin_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // glitch-mode walk: {pin_i, expected pin_o after the edge}
  localparam logic [63:0] GVEC [0:12] = '{
    {32'hFFFF0000, 32'h00000000},
    {32'hFFFF0000, 32'hFFFF0000},
    {32'h0000FFFF, 32'hFFFF0000},
    {32'h00FF00FF, 32'h00FF00FF},
    {32'h00FF00FF, 32'h00FF00FF},
    {32'hAAAAAAAA, 32'h00FF00FF},
    {32'hAAAAAAAA, 32'hAAAAAAAA},
    {32'h55555555, 32'hAAAAAAAA},
    {32'hAAAAAAAA, 32'hAAAAAAAA},
    {32'h55555555, 32'hAAAAAAAA},
    {32'h55555555, 32'h55555555},
    {32'h00000000, 32'h55555555},
    {32'h00000000, 32'h00000000}
  };

  ifl_filter_bank #(.NPINS(NP), .DIV_W(DW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .slow_tick_i  (slow_tick_i),
    .pin_i        (pin_i),
    .flt_on_i     (flt_on_i),
    .flt_off_i    (flt_off_i),
    .sel_glitch_i (sel_glitch_i),
    .sel_bounce_i (sel_bounce_i),
    .div_we_i     (div_we_i),
    .div_i        (div_i),
    .pin_o        (pin_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick_i = 1'b1;
      cyc();
      slow_tick_i = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_div(input int v);
    div_i = DW'(v);
    div_we_i = 1'b1;
    cyc();
    div_we_i = 1'b0;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 and R3: all pins unfiltered after reset, combinational path
    pin_i = 32'h12345678; #1;
    chk("R1 reset pass-through", pin_o, 32'h12345678);
    pin_i = 32'h9ABCDEF0; #1;
    chk("R3 no-edge pass-through", pin_o, 32'h9ABCDEF0);
    pin_i = '0;
    cyc(); cyc();

    // R1 default glitch mode, R4 vector walk
    flt_on_i = '1; cyc(); flt_on_i = '0;
    cyc();
    for (int k = 0; k < 13; k++) begin
      pin_i = GVEC[k][63:32];
      cyc();
      chk($sformatf("R4 glitch vector %0d", k), pin_o, GVEC[k][31:0]);
    end

    // R1: divider value 0 gives a strobe on every slow tick
    sel_bounce_i = 32'h4; cyc(); sel_bounce_i = '0;
    pin_i = 32'h4; cyc();
    tick(1);
    chk("R1 div0 first tick arms", {31'b0, pin_o[2]}, 32'h0);
    tick(1);
    chk("R1 div0 second tick accepts", {31'b0, pin_o[2]}, 32'h1);

    // R2: zero bits of the off mask leave pin 3 filtered
    pin_i = '0; cyc(); cyc();
    flt_off_i = ~32'h8; cyc(); flt_off_i = '0;
    pin_i = 32'h18; cyc();
    chk("R2 off mask zero bit keeps pin3", pin_o & 32'h18, 32'h10);
    pin_i = 32'h0; cyc();
    chk("R2 pin3 one-cycle pulse dropped", pin_o & 32'h8, 32'h0);
    // R2: on and off together leave the pin unfiltered
    flt_on_i = 32'h20; flt_off_i = 32'h20; cyc();
    flt_on_i = '0; flt_off_i = '0;
    pin_i = 32'h20; #1;
    chk("R2 off wins over on", pin_o & 32'h20, 32'h20);
    pin_i = '0; cyc(); cyc();

    // R8, R6, R7: pin0 off, pin1 glitch, pin2 debounce with DIV=2
    flt_on_i = 32'h6; cyc(); flt_on_i = '0;
    wr_div(2);
    pin_i = 32'h7; #1;
    chk("R8 pin0 unfiltered", pin_o & 32'h7, 32'h1);
    cyc();
    chk("R8 pin1 after one edge", pin_o & 32'h7, 32'h1);
    cyc();
    chk("R8 pin1 glitch accepted, pin2 waiting", pin_o & 32'h7, 32'h3);
    tick(5);
    chk("R6 pin2 held before second strobe", {31'b0, pin_o[2]}, 32'h0);
    tick(1);
    chk("R6 pin2 accepted at sixth tick", {31'b0, pin_o[2]}, 32'h1);
    // R7: two-tick low pulse before a strobe
    pin_i = 32'h3; cyc(); tick(2);
    pin_i = 32'h7; cyc(); tick(4);
    chk("R7 short pulse dropped", {31'b0, pin_o[2]}, 32'h1);
    // R7: three-tick pulse that only arms at one strobe
    pin_i = 32'h3; cyc(); tick(3);
    pin_i = 32'h7; cyc(); tick(3);
    chk("R7 one-strobe pulse dropped", {31'b0, pin_o[2]}, 32'h1);
    // R7: long low level
    pin_i = 32'h3; cyc(); tick(5);
    chk("R7 long low held before accept", {31'b0, pin_o[2]}, 32'h1);
    tick(1);
    chk("R7 long low accepted", {31'b0, pin_o[2]}, 32'h0);

    // R9: reload in mid-count restarts the count
    div_i = DW'(2); div_we_i = 1'b1; pin_i = 32'h7; cyc(); div_we_i = 1'b0;
    tick(2);
    wr_div(2);
    tick(5);
    chk("R9 restart delays strobe", {31'b0, pin_o[2]}, 32'h0);
    tick(1);
    chk("R9 accepted after restart", {31'b0, pin_o[2]}, 32'h1);

    // R5: glitch wins when both selects hit pin2; zero bits change nothing
    sel_glitch_i = 32'h4; sel_bounce_i = 32'h4; cyc();
    sel_glitch_i = '0; sel_bounce_i = ~32'h4; cyc(); sel_bounce_i = '0;
    pin_i = 32'h3; cyc();
    chk("R5 pin2 after one edge", {31'b0, pin_o[2]}, 32'h1);
    cyc();
    chk("R5 pin2 glitch mode without ticks", {31'b0, pin_o[2]}, 32'h0);

    // R10: enabling a steady pin shows its level at once
    pin_i = 32'h43; cyc(); cyc(); cyc();
    flt_on_i = 32'h40; cyc(); flt_on_i = '0;
    chk("R10 enable shows steady level", pin_o & 32'h40, 32'h40);

    // R1: reset in mid-run drops every filter
    rst_n = 1'b0; pin_i = 32'hC0FFEE00; #1;
    chk("R1 reset clears enables", pin_o, 32'hC0FFEE00);
    cyc();
    rst_n = 1'b1;
    cyc();
    pin_i = 32'h0F0F0F0F; #1;
    chk("R1 pass-through after second reset", pin_o, 32'h0F0F0F0F);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule